// File: doc/BRIEF.md
# Coprocessor Instruction Issue Receiver

This block is the fabric side of a coprocessor attached to a processor's auxiliary-unit controller. The controller hands over an instruction word, optionally with a 3-bit index for a user-defined instruction it has already decoded. The receiver queues each accepted instruction as a pending result. When the two source operands arrive under their shared valid, the pending entry is filled with their sum, plus the decoded index when one was supplied. The block pushes back on the controller by raising decode-busy while its pending queue is full. The controller then holds instruction-valid high until busy falls.

Nothing reaches the architectural register file speculatively. A result is written only when the controller strobes commit-ok for the oldest pending entry. A flush throws away every pending result and leaves the register file untouched. Independently of this, load words from storage are written into the register named by the most recently accepted instruction. The loaded word is optionally byte-reversed for little-endian storage and then merged lane by lane under byte enables. A registered read port exposes the register file.

Top module: `cop_issue_rx`

## Requirements
- R1: Synchronous active-high reset clears decode-busy, empties the pending queue and sets all four registers to zero.
- R2: An instruction is accepted only on a clock edge where insn_vld_i is high and dec_busy_o is low. An instruction held valid across busy cycles is accepted exactly once, on the first edge after busy falls.
- R3: dec_busy_o is high exactly while the pending queue holds its maximum of two entries. It goes high on the edge that accepts the filling instruction.
- R4: Operand-valid fills the oldest pending entry that has no result yet, with opa_i + opb_i modulo 2^32. It may arrive on the same edge as the instruction it belongs to.
- R5: When udi_vld_i is high on the edge that accepts an instruction, that instruction's result also adds udi_idx_i (zero-extended).
- R6: commit_ok_i writes the oldest pending result, once it is filled, to the register selected by bits [1:0] of its instruction word, and retires it. A commit-ok with no filled oldest entry changes nothing.
- R7: Commit-ok on two consecutive edges retires two successive pending entries, each written once.
- R8: flush_i discards all pending entries without writing the register file. It overrides a commit-ok on the same edge. An instruction accepted on the flush edge is kept as the new oldest entry.
- R9: A load (ld_vld_i high) writes the register selected by bits [3:2] of the most recently accepted instruction. Byte-enable bit k gates data bits [8k+7:8k], and disabled lanes keep their old value.
- R10: With ld_le_i high, the load word is byte-reversed (lane 0 with lane 3, lane 1 with lane 2) before the byte enables are applied.
- R11: rf_rdata_o shows the register addressed by rf_raddr_i one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| insn_vld_i | input | 1 | Instruction word valid |
| udi_idx_i | input | 3 | Index of a controller-decoded user-defined instruction |
| udi_vld_i | input | 1 | Index valid |
| dec_busy_o | output | 1 | Decode busy, pending queue full |
| opa_i | input | 32 | First source operand |
| opb_i | input | 32 | Second source operand |
| opnd_vld_i | input | 1 | Both operands valid |
| flush_i | input | 1 | Discard all pending results |
| commit_ok_i | input | 1 | Oldest pending result may be committed |
| ld_data_i | input | 32 | Load data word |
| ld_vld_i | input | 1 | Load data valid |
| ld_be_i | input | 4 | Load byte enables, bit k for lane k |
| ld_le_i | input | 1 | Little-endian storage order for this load |
| rf_raddr_i | input | 2 | Register read address |
| rf_rdata_o | output | 32 | Registered read data |

## Verification
Decode-busy is due on the edge that accepts the filling instruction. The bench reads it at the following falling edge. Commits and loads land in the register file on their own edge, and the read port adds one more edge. Every register read is therefore stamped with a due cycle one edge after its address is driven, and the monitor compares it only when the cycle counter reaches that stamp. All stimulus is driven at falling edges, and every acceptance decision is taken from the busy value visible half a cycle before the edge that samples it.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  localparam int CPI_DW     = 32;
  localparam int CPI_NREG   = 4;
  localparam int CPI_QDEPTH = 2;
  localparam int CPI_UDIW   = 3;
endpackage

// File: rtl/cpi_load_align.sv
module cpi_load_align #(
  parameter int DW = cpi_pkg::CPI_DW
) (
  input  logic [DW-1:0] data_i,
  input  logic          le_i,
  output logic [DW-1:0] data_o
);
  localparam int NB = DW / 8;

  logic [DW-1:0] swapped;

  // Reverse byte lanes for little-endian storage order.
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign swapped[b*8 +: 8] = data_i[(NB-1-b)*8 +: 8];
  end

  assign data_o = le_i ? swapped : data_i;
endmodule

// File: rtl/cpi_regfile.sv
module cpi_regfile #(
  parameter int DW   = cpi_pkg::CPI_DW,
  parameter int NREG = cpi_pkg::CPI_NREG,
  parameter int AW   = $clog2(NREG),
  parameter int NB   = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          c_we_i,
  input  logic [AW-1:0] c_addr_i,
  input  logic [DW-1:0] c_data_i,
  input  logic          l_we_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic [DW-1:0] l_data_i,
  input  logic [NB-1:0] l_be_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] rdata_q;

  // Commit port writes whole words; enabled load lanes overlay it.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) mem[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        for (int b = 0; b < NB; b++) begin
          if (l_we_i && (l_addr_i == AW'(r)) && l_be_i[b])
            mem[r][b*8 +: 8] <= l_data_i[b*8 +: 8];
          else if (c_we_i && (c_addr_i == AW'(r)))
            mem[r][b*8 +: 8] <= c_data_i[b*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;

  // Assertion support: remember the last commit that had no competing load.
  logic          a_cw_q;
  logic [AW-1:0] a_ca_q;
  logic [DW-1:0] a_cd_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      a_cw_q <= 1'b0;
      a_ca_q <= '0;
      a_cd_q <= '0;
    end else begin
      a_cw_q <= c_we_i && !l_we_i;
      a_ca_q <= c_addr_i;
      a_cd_q <= c_data_i;
    end
  end

  // R6: a committed result is present in its register after the edge.
  a_r6_commit_lands: assert property (@(posedge clk) disable iff (rst)
    a_cw_q |-> mem[a_ca_q] == a_cd_q);
endmodule

// File: rtl/cpi_pend_queue.sv
module cpi_pend_queue #(
  parameter int DW     = cpi_pkg::CPI_DW,
  parameter int AW     = 2,
  parameter int UDIW   = cpi_pkg::CPI_UDIW,
  parameter int QDEPTH = cpi_pkg::CPI_QDEPTH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic [AW-1:0]   push_dest_i,
  input  logic            push_udi_v_i,
  input  logic [UDIW-1:0] push_udi_i,
  input  logic            opnd_vld_i,
  input  logic [DW-1:0]   opa_i,
  input  logic [DW-1:0]   opb_i,
  input  logic            flush_i,
  input  logic            commit_i,
  output logic            full_o,
  output logic            wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o
);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    nxt = (p == PW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [QDEPTH-1:0] vld_q, rdy_q, udv_q;
  logic [AW-1:0]     dest_q [QDEPTH];
  logic [UDIW-1:0]   udi_q  [QDEPTH];
  logic [DW-1:0]     data_q [QDEPTH];
  logic [PW-1:0]     hd_q, tl_q, fl_q;
  logic              full_q;

  logic              pop, fill_ok, fill_new, sel_udv;
  logic [UDIW-1:0]   sel_udi;
  logic [DW-1:0]     udi_ext, sum;
  logic [CW-1:0]     cnt, cnt_base, cnt_nxt;

  // Fill target: oldest entry without a result, possibly pushed this edge.
  assign fill_new = push_i && (tl_q == fl_q) && !vld_q[fl_q];
  assign fill_ok  = opnd_vld_i && !flush_i && !rdy_q[fl_q] && (vld_q[fl_q] || fill_new);
  assign sel_udv  = fill_new ? push_udi_v_i : udv_q[fl_q];
  assign sel_udi  = fill_new ? push_udi_i   : udi_q[fl_q];

  always_comb begin
    udi_ext = '0;
    if (sel_udv) udi_ext[UDIW-1:0] = sel_udi;
    sum = opa_i + opb_i + udi_ext;
  end

  assign pop = commit_i && !flush_i && vld_q[hd_q] && rdy_q[hd_q];

  assign cnt      = CW'($countones(vld_q));
  assign cnt_base = flush_i ? '0 : (cnt - CW'(pop));
  assign cnt_nxt  = cnt_base + CW'(push_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      udv_q  <= '0;
      hd_q   <= '0;
      tl_q   <= '0;
      fl_q   <= '0;
      full_q <= 1'b0;
      for (int i = 0; i < QDEPTH; i++) begin
        dest_q[i] <= '0;
        udi_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (flush_i) begin
        vld_q <= '0;
        rdy_q <= '0;
        hd_q  <= tl_q;
        fl_q  <= tl_q;
      end else if (pop) begin
        vld_q[hd_q] <= 1'b0;
        rdy_q[hd_q] <= 1'b0;
        hd_q        <= nxt(hd_q);
      end
      if (push_i) begin
        vld_q[tl_q]  <= 1'b1;
        rdy_q[tl_q]  <= 1'b0;
        udv_q[tl_q]  <= push_udi_v_i;
        udi_q[tl_q]  <= push_udi_i;
        dest_q[tl_q] <= push_dest_i;
        tl_q         <= nxt(tl_q);
      end
      if (fill_ok) begin
        rdy_q[fl_q]  <= 1'b1;
        data_q[fl_q] <= sum;
        fl_q         <= nxt(fl_q);
      end
      full_q <= (cnt_nxt == CW'(QDEPTH));
    end
  end

  assign full_o    = full_q;
  assign wr_en_o   = pop;
  assign wr_addr_o = dest_q[hd_q];
  assign wr_data_o = data_q[hd_q];

  // R3: never accept into a full queue.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !(&vld_q));
  // R3: registered busy matches the occupancy of the entries.
  a_r3_busy_tracks: assert property (@(posedge clk) disable iff (rst)
    full_o == (&vld_q));
  // R8: after a flush at most the entry accepted on that edge survives.
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> $countones(vld_q) <= 1);
endmodule

// File: rtl/cop_issue_rx.sv
module cop_issue_rx #(
  parameter int DW     = cpi_pkg::CPI_DW,
  parameter int NREG   = cpi_pkg::CPI_NREG,
  parameter int QDEPTH = cpi_pkg::CPI_QDEPTH,
  parameter int UDIW   = cpi_pkg::CPI_UDIW,
  parameter int AW     = $clog2(NREG),
  parameter int NB     = DW / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   insn_i,
  input  logic            insn_vld_i,
  input  logic [UDIW-1:0] udi_idx_i,
  input  logic            udi_vld_i,
  output logic            dec_busy_o,
  input  logic [DW-1:0]   opa_i,
  input  logic [DW-1:0]   opb_i,
  input  logic            opnd_vld_i,
  input  logic            flush_i,
  input  logic            commit_ok_i,
  input  logic [DW-1:0]   ld_data_i,
  input  logic            ld_vld_i,
  input  logic [NB-1:0]   ld_be_i,
  input  logic            ld_le_i,
  input  logic [AW-1:0]   rf_raddr_i,
  output logic [DW-1:0]   rf_rdata_o
);
  logic          busy, acc;
  logic [AW-1:0] ld_tgt_q;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, ld_word;

  assign acc = insn_vld_i && !busy;

  // Load target follows the most recently accepted instruction.
  always_ff @(posedge clk) begin
    if (rst)      ld_tgt_q <= '0;
    else if (acc) ld_tgt_q <= insn_i[AW +: AW];
  end

  cpi_pend_queue #(.DW(DW), .AW(AW), .UDIW(UDIW), .QDEPTH(QDEPTH)) u_queue (
    .clk          (clk),
    .rst          (rst),
    .push_i       (acc),
    .push_dest_i  (insn_i[AW-1:0]),
    .push_udi_v_i (udi_vld_i),
    .push_udi_i   (udi_idx_i),
    .opnd_vld_i   (opnd_vld_i),
    .opa_i        (opa_i),
    .opb_i        (opb_i),
    .flush_i      (flush_i),
    .commit_i     (commit_ok_i),
    .full_o       (busy),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data)
  );

  cpi_load_align #(.DW(DW)) u_align (
    .data_i (ld_data_i),
    .le_i   (ld_le_i),
    .data_o (ld_word)
  );

  cpi_regfile #(.DW(DW), .NREG(NREG), .AW(AW), .NB(NB)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .c_we_i   (wr_en),
    .c_addr_i (wr_addr),
    .c_data_i (wr_data),
    .l_we_i   (ld_vld_i),
    .l_addr_i (ld_tgt_q),
    .l_data_i (ld_word),
    .l_be_i   (ld_be_i),
    .raddr_i  (rf_raddr_i),
    .rdata_o  (rf_rdata_o)
  );

  assign dec_busy_o = busy;

  // R3: busy can only rise on the edge after an instruction was taken.
  a_r3_busy_needs_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_busy_o) |-> $past(acc));
endmodule

// File: tb/cop_issue_rx_tb_top.sv
module cop_issue_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn_i = '0;
  logic        insn_vld_i = 1'b0;
  logic [2:0]  udi_idx_i = '0;
  logic        udi_vld_i = 1'b0;
  logic        dec_busy_o;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        opnd_vld_i = 1'b0;
  logic        flush_i = 1'b0, commit_ok_i = 1'b0;
  logic [31:0] ld_data_i = '0;
  logic        ld_vld_i = 1'b0;
  logic [3:0]  ld_be_i = '0;
  logic        ld_le_i = 1'b0;
  logic [1:0]  rf_raddr_i = '0;
  logic [31:0] rf_rdata_o;

  always #2.5 clk = ~clk;

  cop_issue_rx dut_i (.*);

  int checks = 0, errors = 0, cyc_cnt = 0;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // Reference model of the requirements.
  logic [31:0] model_rf [4];
  int          pq_dest[$];
  logic [31:0] pq_val[$], pq_udi[$];
  bit          pq_rdy[$];
  int          ld_tgt = 0;

  typedef struct { int addr; logic [31:0] data; int due; string tag; } rd_exp_t;
  rd_exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare read data in the cycle it is due.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc_cnt) begin
      rd_exp_t e;
      e = exp_q.pop_front();
      chk(rf_rdata_o === e.data, e.tag, rf_rdata_o, e.data);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  // One clock of stimulus, called at a falling edge.
  task automatic step(input bit iv, input logic [31:0] insn, input bit uv, input logic [2:0] udi,
                      input bit ov, input logic [31:0] a, input logic [31:0] b,
                      input bit fl, input bit co,
                      input bit lv, input logic [31:0] ld, input logic [3:0] be, input bit le,
                      output bit acc);
    logic [31:0] w;
    acc = iv && !dec_busy_o;
    insn_vld_i = iv; insn_i = insn; udi_vld_i = uv; udi_idx_i = udi;
    opnd_vld_i = ov; opa_i = a; opb_i = b;
    flush_i = fl; commit_ok_i = co;
    ld_vld_i = lv; ld_data_i = ld; ld_be_i = be; ld_le_i = le;
    cyc();
    insn_vld_i = 0; udi_vld_i = 0; opnd_vld_i = 0; flush_i = 0; commit_ok_i = 0; ld_vld_i = 0;
    if (fl) begin
      pq_dest.delete(); pq_val.delete(); pq_udi.delete(); pq_rdy.delete();
    end else if (co && pq_dest.size() > 0 && pq_rdy[0]) begin
      model_rf[pq_dest[0]] = pq_val[0];
      void'(pq_dest.pop_front()); void'(pq_val.pop_front());
      void'(pq_udi.pop_front()); void'(pq_rdy.pop_front());
    end
    if (acc) begin
      pq_dest.push_back(int'(insn[1:0])); pq_val.push_back('0);
      pq_udi.push_back(uv ? {29'd0, udi} : 32'd0); pq_rdy.push_back(1'b0);
    end
    if (ov && !fl) begin
      for (int i = 0; i < pq_dest.size(); i++) begin
        if (!pq_rdy[i]) begin
          pq_val[i] = a + b + pq_udi[i];
          pq_rdy[i] = 1'b1;
          break;
        end
      end
    end
    if (lv) begin
      w = le ? {ld[7:0], ld[15:8], ld[23:16], ld[31:24]} : ld;
      for (int k = 0; k < 4; k++) if (be[k]) model_rf[ld_tgt][k*8 +: 8] = w[k*8 +: 8];
    end
    if (acc) ld_tgt = int'(insn[3:2]);
  endtask

  function automatic logic [31:0] mk(input int dest, input int tgt);
    return 32'hC0DE_0000 | (tgt << 2) | dest;
  endfunction

  task automatic ins(input int dest, input int tgt, input bit uv, input logic [2:0] udi);
    bit a;
    do step(1, mk(dest, tgt), uv, udi, 0, 0, 0, 0, 0, 0, 0, 0, 0, a); while (!a);
  endtask
  task automatic ops(input logic [31:0] a, input logic [31:0] b);
    bit x; step(0, 0, 0, 0, 1, a, b, 0, 0, 0, 0, 0, 0, x);
  endtask
  task automatic com();
    bit x; step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, x);
  endtask
  task automatic fls();
    bit x; step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, x);
  endtask
  task automatic lod(input logic [31:0] d, input logic [3:0] be, input bit le);
    bit x; step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, d, be, le, x);
  endtask
  task automatic rd(input int addr, input string tag);
    rd_exp_t e;
    rf_raddr_i = 2'(addr);
    e.addr = addr; e.data = model_rf[addr]; e.due = cyc_cnt + 1; e.tag = tag;
    exp_q.push_back(e);
    cyc();
    cyc();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc_cnt);
    finish_run();
  end

  initial begin
    bit a;
    for (int i = 0; i < 4; i++) model_rf[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc();
    // R1: reset state
    chk(dec_busy_o === 1'b0, "R1 busy", {31'd0, dec_busy_o}, 0);
    for (int i = 0; i < 4; i++) rd(i, "R1 reg zero / R11");

    // R4 R6: basic add and commit
    ins(1, 0, 0, 0); ops(5, 7); com();
    rd(1, "R6 commit r1=12");
    // R4: instruction and operands on the same edge, wrap-around sum
    step(1, mk(2, 0), 0, 0, 1, 32'hFFFF_FFFF, 32'd2, 0, 0, 0, 0, 0, 0, a);
    com(); rd(2, "R4 same-edge wrap");
    // R5: decoded index added
    ins(3, 0, 1, 3'd5); ops(10, 20); com();
    rd(3, "R5 udi add 35");

    // R8: flush discards; R6: commit with nothing pending ignored
    ins(0, 0, 0, 0); ops(1, 1); fls(); com();
    rd(0, "R8 flush keeps r0");

    // R3: busy when two pending
    ins(0, 0, 0, 0); ins(1, 0, 0, 0);
    chk(dec_busy_o === 1'b1, "R3 busy full", {31'd0, dec_busy_o}, 1);
    step(1, mk(2, 0), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, a);
    chk(a == 0, "R2 held while busy", {31'd0, a}, 0);
    ops(3, 4); ops(100, 1);
    // R7: back-to-back commit while an instruction is held valid
    step(1, mk(2, 0), 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, a);
    chk(a == 0, "R2 not taken on busy edge", {31'd0, a}, 0);
    step(1, mk(2, 0), 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, a);
    chk(a == 1, "R2 taken once busy falls", {31'd0, a}, 1);
    chk(dec_busy_o === 1'b0, "R3 busy low one pending", {31'd0, dec_busy_o}, 0);
    rd(0, "R7 first commit r0=7");
    rd(1, "R7 second commit r1=101");
    ops(8, 8); com(); rd(2, "R2 held insn result 16");
    ins(3, 0, 0, 0);
    chk(dec_busy_o === 1'b0, "R2 held insn captured once", {31'd0, dec_busy_o}, 0);

    // R8: flush with an instruction accepted on the same edge
    step(1, mk(3, 1), 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, a);
    chk(a == 1, "R8 accept on flush edge", {31'd0, a}, 1);
    chk(dec_busy_o === 1'b0, "R8 flush leaves one", {31'd0, dec_busy_o}, 0);
    ops(40, 2); com(); rd(3, "R8 kept insn r3=42");
    // R8: flush overrides commit
    ins(0, 2, 0, 0); ops(9, 9);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, a);
    com(); rd(0, "R8 flush beats commit");

    // R9: byte-enabled load into r2 (target bits [3:2] = 2)
    lod(32'h1122_3344, 4'b0101, 0);
    rd(2, "R9 masked load");
    chk(model_rf[2] === 32'h0022_0044, "R9 model", model_rf[2], 32'h0022_0044);
    // R10: little-endian swap then mask
    lod(32'h1122_3344, 4'b1000, 1);
    rd(2, "R10 swapped load");
    chk(model_rf[2] === 32'h4422_0044, "R10 model", model_rf[2], 32'h4422_0044);

    repeat (3) cyc();
    chk(exp_q.size() == 0, "R11 reads drained", exp_q.size(), 0);
    finish_run();
  end
endmodule